// File: doc/BRIEF.md
# Block Erase Queue and Suspend Controller

This block gathers a list of erase blocks that are named one at a time, waits for a quiet acceptance window after the most recent selection, and then works through the listed blocks in order. Each block is handed to a separate per-block erase engine. The controller keeps a 64-bit pending mask with one bit per block. Each new selection re-arms the acceptance window. Once erasing begins, the list is frozen. Blocks that are write-protected are dropped from the list without any error.

The controller supports two kinds of suspend. A suspend that arrives during the acceptance window pauses the operation at once, and a later resume launches the erase with no further wait. A suspend that arrives while a block is being erased stops the engine on the next cycle. The suspended flag is raised only after a fixed halt latency. The interrupted block is erased again from its start when the operation resumes. A resume is honoured only while the read-array indication is high, and the suspend/resume cycle may repeat any number of times. When every listed block is protected, the operation still appears to start and then ends after a fixed duration. All windows are counted in clock cycles.

Top module: `erq_ctrl`

## Requirements
- R1: After reset, `busy`, `started`, `suspended`, `finished` and `eng_run` are low and `erase_mask` is zero.
- R2: A `sel_valid` pulse accepted while idle or collecting sets bit `sel_block` of `erase_mask`, where bit index equals block number 0..63.
- R3: `started` rises exactly WINDOW_CYC clock edges after the edge that accepted the most recent selection. Each accepted selection restarts the window.
- R4: Once `started` is high, further selections add no bit to `erase_mask`.
- R5: At launch, blocks whose bit is set in `prot_mask` are removed from `erase_mask`. The remaining blocks are driven on `cur_block` with `eng_run` high in ascending block-number order. An `eng_done` pulse clears the current block's bit and advances to the next block.
- R6: If every listed block is protected, `started` rises, `eng_run` stays low, and `finished` rises ALLPROT_CYC edges after `started` rose.
- R7: A `suspend_req` during the acceptance window raises `suspended` on the next edge. Selections are ignored while suspended. An accepted resume raises `started` and `eng_run` on the next edge.
- R8: A `suspend_req` while `eng_run` is high drops `eng_run` on the next edge. `suspended` rises HALT_CYC edges after the accepting edge, and `eng_done` is ignored in the meantime.
- R9: `resume_req` is ignored unless `read_array` is high at the same edge.
- R10: A resume after a suspend that arrived during erasing restarts the same `cur_block`. Suspend and resume may be repeated.
- R11: After the last block's `eng_done`, `finished` is high for exactly one cycle. The block is then idle with `busy` low and `erase_mask` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_valid | input | 1 | Block selection pulse |
| sel_block | input | 6 | Block number for the selection |
| suspend_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| read_array | input | 1 | High when the device is back in read-array mode |
| prot_mask | input | 64 | Per-block protection, bit n protects block n |
| eng_done | input | 1 | Erase engine finished the current block |
| eng_run | output | 1 | Erase engine should work on `cur_block` |
| cur_block | output | 6 | Block currently being erased |
| erase_mask | output | 64 | Blocks still listed for erasure |
| started | output | 1 | Erase operation has launched |
| suspended | output | 1 | Operation is suspended |
| busy | output | 1 | Operation in progress |
| finished | output | 1 | One-cycle pulse at completion |

## Verification
The bound assertions check several properties on every cycle. They check that no new mask bit appears after launch, that the engine only runs on a listed block, that an early suspend takes hold on the next edge, that a running engine stops one edge after a suspend, that a resume is only taken while read-array is high, and that the completion pulse is one cycle wide and leaves an empty list. The exact acceptance-window length and its restart, the halt latency, and the all-protected duration are shown only by the bench's timed scenarios. The same holds for the ascending erase order with protected blocks skipped and the restart of the interrupted block after resume.

// File: rtl/erq_pkg.sv
package erq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ERASE,
        ST_HALTING,
        ST_PAUSED,
        ST_PROTWAIT,
        ST_DONE
    } erq_state_e;

    typedef struct packed {
        logic set;
        logic clear;
        logic prune;
        logic flush;
    } mask_ctl_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/erq_tick.sv
module erq_tick #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign expired = (cnt_inc == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt_inc[CW-1:0];
    end
endmodule

// File: rtl/erq_pick.sv
module erq_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/erq_selmask.sv
module erq_selmask
    import erq_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  mask_ctl_t     ctl,
    input  logic [IW-1:0] set_idx,
    input  logic [IW-1:0] clr_idx,
    input  logic [N-1:0]  prot,
    output logic [N-1:0]  mask
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || ctl.flush)                     mask[g] <= 1'b0;
            else if (ctl.prune)                       mask[g] <= mask[g] & ~prot[g];
            else if (ctl.set && set_idx == IW'(g))    mask[g] <= 1'b1;
            else if (ctl.clear && clr_idx == IW'(g))  mask[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/erq_ctrl.sv
module erq_ctrl
    import erq_pkg::*;
#(
    parameter int NUM_BLK     = 64,
    parameter int WINDOW_CYC  = 50,
    parameter int HALT_CYC    = 15,
    parameter int ALLPROT_CYC = 100
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sel_valid,
    input  logic [$clog2(NUM_BLK)-1:0] sel_block,
    input  logic                       suspend_req,
    input  logic                       resume_req,
    input  logic                       read_array,
    input  logic [NUM_BLK-1:0]         prot_mask,
    input  logic                       eng_done,
    output logic                       eng_run,
    output logic [$clog2(NUM_BLK)-1:0] cur_block,
    output logic [NUM_BLK-1:0]         erase_mask,
    output logic                       started,
    output logic                       suspended,
    output logic                       busy,
    output logic                       finished
);
    localparam int BLK_W = $clog2(NUM_BLK);
    localparam int MAXL  = max3(WINDOW_CYC, HALT_CYC, ALLPROT_CYC);
    localparam int CNT_W = $clog2(MAXL + 1);

    erq_state_e          state_q, state_nx;
    logic                pre_q, pre_nx;
    logic [BLK_W-1:0]    cur_q, cur_nx;
    mask_ctl_t           ctl;
    logic [NUM_BLK-1:0]  mask_q;
    logic [NUM_BLK-1:0]  pick_in;
    logic [BLK_W-1:0]    pick_idx;
    logic                pick_any;
    logic [CNT_W-1:0]    tmr_limit;
    logic                tmr_clr;
    logic                tmr_exp;
    logic                sel_take;
    logic                resume_ok;

    // Candidate list: at launch the unprotected listed blocks, while
    // erasing the listed blocks minus the one in progress.
    assign pick_in = (state_q == ST_ERASE)
                   ? (mask_q & ~(NUM_BLK'(1) << cur_q))
                   : (mask_q & ~prot_mask);

    erq_pick #(.N(NUM_BLK), .IW(BLK_W)) u_pick (
        .vec (pick_in),
        .idx (pick_idx),
        .any (pick_any)
    );

    erq_selmask #(.N(NUM_BLK), .IW(BLK_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .set_idx (sel_block),
        .clr_idx (cur_q),
        .prot    (prot_mask),
        .mask    (mask_q)
    );

    always_comb begin
        case (state_q)
            ST_HALTING:  tmr_limit = CNT_W'(HALT_CYC);
            ST_PROTWAIT: tmr_limit = CNT_W'(ALLPROT_CYC);
            default:     tmr_limit = CNT_W'(WINDOW_CYC);
        endcase
    end

    erq_tick #(.CW(CNT_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    assign resume_ok = resume_req && read_array;

    always_comb begin
        state_nx = state_q;
        pre_nx   = pre_q;
        cur_nx   = cur_q;
        ctl      = '0;
        sel_take = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sel_valid) begin
                    sel_take = 1'b1;
                    ctl.set  = 1'b1;
                    state_nx = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (suspend_req) begin
                    pre_nx   = 1'b1;
                    state_nx = ST_PAUSED;
                end else if (sel_valid) begin
                    sel_take = 1'b1;
                    ctl.set  = 1'b1;
                end else if (tmr_exp) begin
                    ctl.prune = 1'b1;
                    cur_nx    = pick_idx;
                    state_nx  = pick_any ? ST_ERASE : ST_PROTWAIT;
                end
            end
            ST_ERASE: begin
                if (suspend_req) begin
                    state_nx = ST_HALTING;
                end else if (eng_done) begin
                    ctl.clear = 1'b1;
                    if (pick_any) cur_nx = pick_idx;
                    else          state_nx = ST_DONE;
                end
            end
            ST_HALTING: begin
                if (tmr_exp) begin
                    pre_nx   = 1'b0;
                    state_nx = ST_PAUSED;
                end
            end
            ST_PAUSED: begin
                if (resume_ok) begin
                    pre_nx = 1'b0;
                    if (pre_q) begin
                        ctl.prune = 1'b1;
                        cur_nx    = pick_idx;
                        state_nx  = pick_any ? ST_ERASE : ST_PROTWAIT;
                    end else begin
                        state_nx = ST_ERASE;
                    end
                end
            end
            ST_PROTWAIT: begin
                if (tmr_exp) state_nx = ST_DONE;
            end
            ST_DONE: begin
                ctl.flush = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign tmr_clr = (state_nx != state_q) || sel_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pre_q   <= 1'b0;
            cur_q   <= '0;
        end else begin
            state_q <= state_nx;
            pre_q   <= pre_nx;
            cur_q   <= cur_nx;
        end
    end

    assign eng_run    = (state_q == ST_ERASE);
    assign cur_block  = cur_q;
    assign erase_mask = mask_q;
    assign suspended  = (state_q == ST_PAUSED);
    assign finished   = (state_q == ST_DONE);
    assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign started    = (state_q == ST_ERASE) || (state_q == ST_HALTING) ||
                        (state_q == ST_PROTWAIT) ||
                        ((state_q == ST_PAUSED) && !pre_q);
endmodule

// File: rtl/erq_ctrl_chk.sv
module erq_ctrl_chk #(
    parameter int NUM_BLK = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       suspend_req,
    input logic                       resume_req,
    input logic                       read_array,
    input logic                       eng_run,
    input logic [$clog2(NUM_BLK)-1:0] cur_block,
    input logic [NUM_BLK-1:0]         erase_mask,
    input logic                       started,
    input logic                       suspended,
    input logic                       busy,
    input logic                       finished
);
    a_r4_no_add_after_start: assert property (@(posedge clk) disable iff (rst)
        started |=> ((erase_mask & ~$past(erase_mask)) == '0));

    a_r5_run_on_listed: assert property (@(posedge clk) disable iff (rst)
        eng_run |-> erase_mask[cur_block]);

    a_r7_early_suspend: assert property (@(posedge clk) disable iff (rst)
        (busy && !started && !suspended && suspend_req) |=> suspended);

    a_r8_engine_stops: assert property (@(posedge clk) disable iff (rst)
        (eng_run && suspend_req) |=> !eng_run);

    a_r9_resume_gate: assert property (@(posedge clk) disable iff (rst)
        $fell(suspended) |-> $past(resume_req && read_array));

    a_r11_finish_pulse: assert property (@(posedge clk) disable iff (rst)
        finished |=> (!finished && !busy && erase_mask == '0));
endmodule

bind erq_ctrl erq_ctrl_chk #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .suspend_req (suspend_req),
    .resume_req  (resume_req),
    .read_array  (read_array),
    .eng_run     (eng_run),
    .cur_block   (cur_block),
    .erase_mask  (erase_mask),
    .started     (started),
    .suspended   (suspended),
    .busy        (busy),
    .finished    (finished)
);

// File: tb/erq_ctrl_tb.sv
`timescale 1ns/1ps
module erq_ctrl_tb;
    localparam int NB  = 64;
    localparam int W   = 20;
    localparam int L   = 6;
    localparam int A   = 12;
    localparam int ENG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_valid = 1'b0;
    logic [5:0]    sel_block = '0;
    logic          suspend_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          read_array = 1'b1;
    logic [NB-1:0] prot_mask = '0;
    logic          eng_done;
    logic          eng_run;
    logic [5:0]    cur_block;
    logic [NB-1:0] erase_mask;
    logic          started, suspended, busy, finished;

    int checks = 0;
    int fails  = 0;
    int log_n  = 0;
    int log_b [16];
    int eng_cnt = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    erq_ctrl #(.NUM_BLK(NB), .WINDOW_CYC(W), .HALT_CYC(L), .ALLPROT_CYC(A)) u_dut (
        .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_block(sel_block),
        .suspend_req(suspend_req), .resume_req(resume_req), .read_array(read_array),
        .prot_mask(prot_mask), .eng_done(eng_done), .eng_run(eng_run),
        .cur_block(cur_block), .erase_mask(erase_mask), .started(started),
        .suspended(suspended), .busy(busy), .finished(finished)
    );

    // Erase engine model: ENG cycles of eng_run per block, restarted when halted.
    initial begin
        eng_done = 1'b0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_run && !rst) begin
                eng_cnt++;
                if (eng_cnt == ENG) begin
                    eng_done = 1'b1;
                    eng_cnt  = 0;
                    if (log_n < 16) log_b[log_n] = int'(cur_block);
                    log_n++;
                end
            end else begin
                eng_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sel(input int b);
        @(negedge clk);
        sel_valid = 1'b1;
        sel_block = 6'(b);
        @(negedge clk);
        sel_valid = 1'b0;
    endtask

    task automatic pulse_suspend();
        @(negedge clk);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
    endtask

    task automatic wait_finish(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            #1;
            if (finished) begin
                seen = 1'b1;
                break;
            end
        end
        chk(req, "finished seen", 64'(seen), 64'd1);
        wait_edges(1);
        chk(req, "finished one cycle", 64'(finished), 64'd0);
        chk(req, "idle after finish", 64'(busy), 64'd0);
        chk(req, "mask empty after finish", erase_mask, 64'd0);
    endtask

    function automatic logic [63:0] bit_of(input int b);
        return 64'd1 << b;
    endfunction

    task automatic t_reset();
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "started", 64'(started), 64'd0);
        chk("R1", "suspended", 64'(suspended), 64'd0);
        chk("R1", "finished", 64'(finished), 64'd0);
        chk("R1", "eng_run", 64'(eng_run), 64'd0);
        chk("R1", "erase_mask", erase_mask, 64'd0);
    endtask

    task automatic t_order_and_window();
        log_n = 0;
        pulse_sel(9);
        chk("R2", "mask after block 9", erase_mask, bit_of(9));
        wait_edges(5);
        pulse_sel(3);
        wait_edges(10);
        chk("R3", "not started mid window", 64'(started), 64'd0);
        pulse_sel(40);
        chk("R2", "mask after three", erase_mask, bit_of(9) | bit_of(3) | bit_of(40));
        wait_edges(W - 1);
        chk("R3", "started one edge early", 64'(started), 64'd0);
        wait_edges(1);
        chk("R3", "started on window end", 64'(started), 64'd1);
        chk("R5", "first block lowest", 64'(cur_block), 64'd3);
        pulse_sel(1);
        chk("R4", "late selection ignored", erase_mask, bit_of(9) | bit_of(3) | bit_of(40));
        wait_finish("R11");
        chk("R5", "blocks erased", 64'(log_n), 64'd3);
        chk("R5", "order 1st", 64'(log_b[0]), 64'd3);
        chk("R5", "order 2nd", 64'(log_b[1]), 64'd9);
        chk("R5", "order 3rd", 64'(log_b[2]), 64'd40);
    endtask

    task automatic t_skip_protected();
        log_n = 0;
        prot_mask = bit_of(5) | bit_of(7);
        pulse_sel(5);
        pulse_sel(6);
        pulse_sel(7);
        wait_edges(W);
        chk("R5", "protected pruned", erase_mask, bit_of(6));
        chk("R5", "current unprotected", 64'(cur_block), 64'd6);
        wait_finish("R11");
        chk("R5", "only one erased", 64'(log_n), 64'd1);
        chk("R5", "erased block", 64'(log_b[0]), 64'd6);
    endtask

    task automatic t_all_protected();
        log_n = 0;
        prot_mask = bit_of(5) | bit_of(7);
        pulse_sel(7);
        pulse_sel(5);
        wait_edges(W);
        chk("R6", "started", 64'(started), 64'd1);
        chk("R6", "engine idle", 64'(eng_run), 64'd0);
        wait_edges(A - 1);
        chk("R6", "not finished early", 64'(finished), 64'd0);
        wait_edges(1);
        chk("R6", "finished on time", 64'(finished), 64'd1);
        wait_edges(1);
        chk("R6", "idle after", 64'(busy), 64'd0);
        chk("R6", "nothing erased", 64'(log_n), 64'd0);
        prot_mask = '0;
    endtask

    task automatic t_early_suspend();
        log_n = 0;
        pulse_sel(12);
        wait_edges(3);
        pulse_suspend();
        chk("R7", "suspended next edge", 64'(suspended), 64'd1);
        chk("R7", "not started", 64'(started), 64'd0);
        pulse_sel(13);
        chk("R7", "selection while paused ignored", erase_mask, bit_of(12));
        wait_edges(W + 2);
        chk("R7", "no launch while paused", 64'(started), 64'd0);
        read_array = 1'b0;
        pulse_resume();
        wait_edges(3);
        chk("R9", "resume ignored off read-array", 64'(suspended), 64'd1);
        chk("R9", "still not started", 64'(started), 64'd0);
        read_array = 1'b1;
        pulse_resume();
        chk("R7", "started at once", 64'(started), 64'd1);
        chk("R7", "engine at once", 64'(eng_run), 64'd1);
        chk("R7", "block", 64'(cur_block), 64'd12);
        wait_finish("R11");
        chk("R7", "erased blocks", 64'(log_n), 64'd1);
    endtask

    task automatic t_late_suspend();
        log_n = 0;
        pulse_sel(4);
        pulse_sel(2);
        wait_edges(W);
        chk("R5", "first block", 64'(cur_block), 64'd2);
        pulse_suspend();
        chk("R8", "engine stopped", 64'(eng_run), 64'd0);
        wait_edges(L - 1);
        chk("R8", "not suspended early", 64'(suspended), 64'd0);
        wait_edges(1);
        chk("R8", "suspended on time", 64'(suspended), 64'd1);
        chk("R8", "block kept listed", erase_mask, bit_of(2) | bit_of(4));
        pulse_resume();
        chk("R10", "engine resumed", 64'(eng_run), 64'd1);
        chk("R10", "same block", 64'(cur_block), 64'd2);
        pulse_suspend();
        wait_edges(L + 1);
        chk("R10", "second suspend", 64'(suspended), 64'd1);
        pulse_resume();
        chk("R10", "second resume block", 64'(cur_block), 64'd2);
        wait_finish("R11");
        chk("R10", "erased blocks", 64'(log_n), 64'd2);
        chk("R10", "order 1st", 64'(log_b[0]), 64'd2);
        chk("R10", "order 2nd", 64'(log_b[1]), 64'd4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_edges(1);
        t_reset();
        t_order_and_window();
        t_skip_protected();
        t_all_protected();
        t_early_suspend();
        t_late_suspend();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule